// File: doc/BRIEF.md
# Iterative Sigma-Delta Reconstruction Engine

This block takes a record of samples that have already passed through a sigma-delta conversion chain and recovers a closer estimate of the signal that produced them. It holds a bit-accurate digital model of that chain: a first-order modulator with a multi-bit quantizer, followed by a boxcar low-pass filter. The engine runs this model repeatedly over an on-chip buffer. On each pass it compares the model's response to the current estimate with the observed record, and moves the estimate by a relaxation-weighted share of the difference. After enough passes the chain of estimates approaches the inverse of the distortion.

A record of `DEPTH` signed fixed-point words is streamed in over a valid/ready port. The pass count and the relaxation factor are captured together with the first word. The engine then works through its passes without further input. Finally it streams the refined record out over a valid/ready port, in index order. A `busy` flag covers the whole job.

Top module: `isdr_engine`

## Requirements
- R1: While idle, `in_ready` is high and `busy` is low. The first accepted word raises `busy`. Exactly `DEPTH` words form a record, and after the last of them `in_ready` stays low until the job ends.
- R2: With a captured pass count of 0, the output record equals the input record word for word.
- R3: The operator model integrates as v[n] = sat(v[n-1] + s[n] - d[n-1]). It quantizes as d[n] = clamp(floor(v[n] / 2^SH), -2^(Q_BITS-1), 2^(Q_BITS-1)-1) * 2^SH, where SH = FRAC_W - Q_BITS + 1, so full scale is ±1.0 in a signed format with FRAC_W fractional bits.
- R4: The operator output g[n] is the sum of d[n] and the TAPS-1 previous quantizer outputs, shifted arithmetically right by log2(TAPS).
- R5: Each pass computes x_new[n] = sat(x_old[n] + sat(floor((y[n] - g[n]) * relax / 2^LAM_FRAC + 1/2))). Here y is the input record, g is the operator applied to x_old, and relax is unsigned with LAM_FRAC fractional bits, so 64 means 1.0 by default.
- R6: The integrator, the feedback value and the filter history are zero at the start of every pass and of every record.
- R7: `pass_count` (0 to 15) and `relax` are captured only at the first accepted word of a record. Changes to them afterwards have no effect on that record.
- R8: The output stream delivers `DEPTH` words in index order. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold steady.
- R9: `busy` falls in the cycle after the last output word is accepted, and `in_ready` is high again from that cycle on.
- R10: Words offered on the input while a job is running are neither accepted nor do they alter the output record.
- R11: All sums and relaxation products saturate to the signed 32-bit range rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Engine can accept an input word |
| in_data | input | DATA_W | Observed sample, signed fixed point |
| pass_count | input | PASS_W | Number of refinement passes, captured with the first word |
| relax | input | LAM_W | Relaxation factor, unsigned with LAM_FRAC fractional bits |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | DATA_W | Refined sample, signed fixed point |
| busy | output | 1 | Job in progress |

## Verification
The pass timing inside the engine is not visible at the ports, so the bench does not predict the output cycle. It compares each word in the cycle where `out_valid` and `out_ready` are both high, which it sees at the falling edge before the accepting edge. The `busy` and `in_ready` transitions are due one edge after the handshake that causes them, and the bench samples them at the next falling edge. Expected words come from an arithmetic model of the recurrences in R3 to R5, run over whole records.

// File: rtl/isdr_pkg.sv
package isdr_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_CLEAR,
    S_RUN,
    S_DRAIN,
    S_ORD,
    S_OCAP,
    S_OHOLD
  } seq_state_t;
endpackage

// File: rtl/isdr_sample_ram.sv
module isdr_sample_ram #(
  parameter int DEPTH = 5000,
  parameter int WIDTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/isdr_operator.sv
module isdr_operator #(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 16,
  parameter int Q_BITS = 3,
  parameter int TAPS   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_sample,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_sample
);
  localparam int SH     = FRAC_W - Q_BITS + 1;
  localparam int TAP_SH = $clog2(TAPS);
  localparam int IW     = DATA_W + 2;
  localparam int SW     = DATA_W + TAP_SH + 1;
  localparam logic signed [IW-1:0] ACC_HI = {{(IW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [IW-1:0] ACC_LO = {{(IW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
  localparam logic signed [DATA_W-1:0] CODE_HI = DATA_W'((2**(Q_BITS-1)) - 1);
  localparam logic signed [DATA_W-1:0] CODE_LO = -DATA_W'(2**(Q_BITS-1));

  logic signed [DATA_W-1:0] integ_q;
  logic signed [DATA_W-1:0] hist [TAPS-1];

  logic signed [IW-1:0]     acc_w;
  logic signed [DATA_W-1:0] integ_nx;
  logic signed [DATA_W-1:0] code_raw;
  logic signed [DATA_W-1:0] code_sel;
  logic signed [DATA_W-1:0] dq;
  logic signed [SW-1:0]     sum_w;
  logic signed [DATA_W-1:0] filt_nx;

  // Integrator with saturation; feedback is the previous quantizer level.
  always_comb begin
    acc_w = IW'(integ_q) + IW'(in_sample) - IW'(hist[0]);
    if (acc_w > ACC_HI)      integ_nx = ACC_HI[DATA_W-1:0];
    else if (acc_w < ACC_LO) integ_nx = ACC_LO[DATA_W-1:0];
    else                     integ_nx = acc_w[DATA_W-1:0];
  end

  // Multi-bit quantizer: floor to the level grid, clamp to Q_BITS codes.
  always_comb begin
    code_raw = integ_nx >>> SH;
    if (code_raw > CODE_HI)      code_sel = CODE_HI;
    else if (code_raw < CODE_LO) code_sel = CODE_LO;
    else                         code_sel = code_raw;
    dq = code_sel <<< SH;
  end

  // Boxcar low-pass over the newest level and TAPS-1 older ones.
  always_comb begin
    sum_w = SW'(dq);
    for (int i = 0; i < TAPS - 1; i++) sum_w = sum_w + SW'(hist[i]);
    filt_nx = DATA_W'(sum_w >>> TAP_SH);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      integ_q    <= '0;
      out_valid  <= 1'b0;
      out_sample <= '0;
      for (int i = 0; i < TAPS - 1; i++) hist[i] <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        integ_q    <= integ_nx;
        out_sample <= filt_nx;
        hist[0]    <= dq;
        for (int i = 1; i < TAPS - 1; i++) hist[i] <= hist[i-1];
      end
    end
  end

  AST_QUANT_GRID: assert property (@(posedge clk) disable iff (rst)
    (hist[0][SH-1:0] == '0) && ((hist[0] >>> SH) <= CODE_HI) && ((hist[0] >>> SH) >= CODE_LO)); // R3
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    clear |=> (integ_q == '0) && !out_valid && (hist[0] == '0)); // R6
  AST_FILTER_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !clear) |=> out_valid); // R4
endmodule

// File: rtl/isdr_update.sv
module isdr_update #(
  parameter int DATA_W   = 32,
  parameter int LAM_W    = 8,
  parameter int LAM_FRAC = 6,
  parameter int AW       = 13
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [AW-1:0]            in_addr,
  input  logic signed [DATA_W-1:0] est,
  input  logic signed [DATA_W-1:0] obs,
  input  logic signed [DATA_W-1:0] model,
  input  logic [LAM_W-1:0]         lam,
  output logic                     out_valid,
  output logic [AW-1:0]            out_addr,
  output logic signed [DATA_W-1:0] out_data
);
  localparam int RW = DATA_W + 1;
  localparam int PW = RW + LAM_W + 1;
  localparam logic signed [PW-1:0] HALF  = PW'(1) <<< (LAM_FRAC - 1);
  localparam logic signed [PW-1:0] P_HI  = {{(PW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [PW-1:0] P_LO  = {{(PW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
  localparam logic signed [RW-1:0] S_HI  = {2'b00, {(DATA_W-1){1'b1}}};
  localparam logic signed [RW-1:0] S_LO  = {2'b11, {(DATA_W-1){1'b0}}};

  logic signed [RW-1:0]     resid;
  logic signed [PW-1:0]     prod;
  logic signed [PW-1:0]     scaled;
  logic signed [DATA_W-1:0] step;
  logic signed [RW-1:0]     sum_w;
  logic signed [DATA_W-1:0] next_est;

  always_comb begin
    resid  = RW'(obs) - RW'(model);
    prod   = PW'(resid) * PW'($signed({1'b0, lam}));
    scaled = (prod + HALF) >>> LAM_FRAC;
    if (scaled > P_HI)      step = P_HI[DATA_W-1:0];
    else if (scaled < P_LO) step = P_LO[DATA_W-1:0];
    else                    step = scaled[DATA_W-1:0];
    sum_w = RW'(est) + RW'(step);
    if (sum_w > S_HI)      next_est = S_HI[DATA_W-1:0];
    else if (sum_w < S_LO) next_est = S_LO[DATA_W-1:0];
    else                   next_est = sum_w[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr <= in_addr;
        out_data <= next_est;
      end
    end
  end

  AST_UPDATE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid && (out_addr == $past(in_addr))); // R5
  AST_ZERO_RESIDUAL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (obs == model)) |=> (out_data == $past(est))); // R5
endmodule

// File: rtl/isdr_engine.sv
module isdr_engine
  import isdr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int FRAC_W   = 16,
  parameter int Q_BITS   = 3,
  parameter int TAPS     = 4,
  parameter int DEPTH    = 5000,
  parameter int LAM_W    = 8,
  parameter int LAM_FRAC = 6,
  parameter int PASS_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [PASS_W-1:0] pass_count,
  input  logic [LAM_W-1:0]  relax,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              busy
);
  localparam int AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int DRAIN_CYC = 3;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  seq_state_t        state;
  logic [AW-1:0]     idx;
  logic [PASS_W-1:0] passes_q;
  logic [PASS_W-1:0] pass_done;
  logic [PASS_W-1:0] pass_nx;
  logic [LAM_W-1:0]  lam_q;
  logic [1:0]        drain_cnt;
  logic              busy_q;
  logic              out_valid_q;
  logic [DATA_W-1:0] out_data_q;

  logic              in_fire;
  logic              rd_en;
  logic signed [DATA_W-1:0] x_rd;
  logic signed [DATA_W-1:0] y_rd;
  logic              rd_vld_d0;
  logic [AW-1:0]     addr_d0;
  logic [AW-1:0]     addr_d1;
  logic signed [DATA_W-1:0] est_d1;
  logic signed [DATA_W-1:0] obs_d1;
  logic              op_valid;
  logic signed [DATA_W-1:0] op_out;
  logic              upd_valid;
  logic [AW-1:0]     upd_addr;
  logic signed [DATA_W-1:0] upd_data;
  logic              x_we;
  logic [AW-1:0]     x_waddr;
  logic [DATA_W-1:0] x_wdata;

  assign in_ready  = (state == S_IDLE) || (state == S_LOAD);
  assign in_fire   = in_valid && in_ready;
  assign rd_en     = (state == S_RUN) || (state == S_ORD);
  assign pass_nx   = pass_done + 1'b1;
  assign busy      = busy_q;
  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;

  // Estimate buffer: loaded from input, rewritten by the update stage.
  assign x_we    = in_fire || upd_valid;
  assign x_waddr = in_fire ? idx : upd_addr;
  assign x_wdata = in_fire ? in_data : upd_data;

  isdr_sample_ram #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_est_ram (
    .clk     (clk),
    .wr_en   (x_we),
    .wr_addr (x_waddr),
    .wr_data (x_wdata),
    .rd_en   (rd_en),
    .rd_addr (idx),
    .rd_data (x_rd)
  );

  isdr_sample_ram #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_obs_ram (
    .clk     (clk),
    .wr_en   (in_fire),
    .wr_addr (idx),
    .wr_data (in_data),
    .rd_en   (state == S_RUN),
    .rd_addr (idx),
    .rd_data (y_rd)
  );

  // Read-side pipeline alignment for the operator and update stages.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld_d0 <= 1'b0;
      addr_d0   <= '0;
      addr_d1   <= '0;
      est_d1    <= '0;
      obs_d1    <= '0;
    end else begin
      rd_vld_d0 <= (state == S_RUN);
      addr_d0   <= idx;
      addr_d1   <= addr_d0;
      est_d1    <= x_rd;
      obs_d1    <= y_rd;
    end
  end

  isdr_operator #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .Q_BITS(Q_BITS), .TAPS(TAPS)) u_operator (
    .clk        (clk),
    .rst        (rst),
    .clear      (state == S_CLEAR),
    .in_valid   (rd_vld_d0),
    .in_sample  (x_rd),
    .out_valid  (op_valid),
    .out_sample (op_out)
  );

  isdr_update #(.DATA_W(DATA_W), .LAM_W(LAM_W), .LAM_FRAC(LAM_FRAC), .AW(AW)) u_update (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (op_valid),
    .in_addr   (addr_d1),
    .est       (est_d1),
    .obs       (obs_d1),
    .model     (op_out),
    .lam       (lam_q),
    .out_valid (upd_valid),
    .out_addr  (upd_addr),
    .out_data  (upd_data)
  );

  // Sequencer: load, per-pass clear/run/drain, then output.
  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      idx         <= '0;
      passes_q    <= '0;
      pass_done   <= '0;
      lam_q       <= '0;
      drain_cnt   <= '0;
      busy_q      <= 1'b0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (in_fire) begin
            busy_q    <= 1'b1;
            passes_q  <= pass_count;
            lam_q     <= relax;
            pass_done <= '0;
            idx       <= idx + 1'b1;
            state     <= S_LOAD;
          end
        end
        S_LOAD: begin
          if (in_fire) begin
            if (idx == LAST) begin
              idx   <= '0;
              state <= (passes_q == '0) ? S_ORD : S_CLEAR;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        S_CLEAR: state <= S_RUN;
        S_RUN: begin
          if (idx == LAST) begin
            idx       <= '0;
            drain_cnt <= '0;
            state     <= S_DRAIN;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_DRAIN: begin
          drain_cnt <= drain_cnt + 1'b1;
          if (drain_cnt == 2'(DRAIN_CYC - 1)) begin
            pass_done <= pass_nx;
            state     <= (pass_nx == passes_q) ? S_ORD : S_CLEAR;
          end
        end
        S_ORD: state <= S_OCAP;
        S_OCAP: begin
          out_data_q  <= x_rd;
          out_valid_q <= 1'b1;
          state       <= S_OHOLD;
        end
        S_OHOLD: begin
          if (out_ready) begin
            out_valid_q <= 1'b0;
            if (idx == LAST) begin
              idx    <= '0;
              busy_q <= 1'b0;
              state  <= S_IDLE;
            end else begin
              idx   <= idx + 1'b1;
              state <= S_ORD;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data)); // R8
  AST_OUT_IN_JOB: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy); // R9
  AST_FIRST_WORD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (in_fire && (state == S_IDLE)) |-> !busy); // R1
  AST_SETTINGS_HELD: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE) |=> $stable(passes_q) && $stable(lam_q)); // R7
  AST_PASS_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state == S_RUN) |-> (pass_done < passes_q)); // R7
  AST_NO_LOAD_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> !in_fire); // R10
endmodule

// File: tb/isdr_engine_bench.sv
module isdr_engine_bench;
  localparam int DATA_W   = 32;
  localparam int FRAC_W   = 16;
  localparam int Q_BITS   = 3;
  localparam int TAPS     = 4;
  localparam int DEPTH    = 8;
  localparam int LAM_W    = 8;
  localparam int LAM_FRAC = 6;
  localparam int PASS_W   = 4;
  localparam int SH       = FRAC_W - Q_BITS + 1;
  localparam int TSH      = $clog2(TAPS);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic [PASS_W-1:0] pass_count = '0;
  logic [LAM_W-1:0]  relax = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [DATA_W-1:0] out_data;
  logic              busy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  longint rec [DEPTH];
  longint expv [DEPTH];

  always #4 clk = ~clk;

  isdr_engine #(
    .DATA_W(DATA_W), .FRAC_W(FRAC_W), .Q_BITS(Q_BITS), .TAPS(TAPS),
    .DEPTH(DEPTH), .LAM_W(LAM_W), .LAM_FRAC(LAM_FRAC), .PASS_W(PASS_W)
  ) u_isdr_engine (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .pass_count(pass_count), .relax(relax),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .busy(busy)
  );

  function automatic longint sat32(longint v);
    if (v > 64'sd2147483647) return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  // Arithmetic model of R3, R4, R5, R6, R11 over a whole record.
  function automatic void model(int npass, int lam);
    longint x [DEPTH];
    longint g [DEPTH];
    longint h [TAPS-1];
    longint v, code, d, sum, r, p;
    for (int n = 0; n < DEPTH; n++) x[n] = rec[n];
    for (int k = 0; k < npass; k++) begin
      v = 0;
      for (int j = 0; j < TAPS - 1; j++) h[j] = 0;
      for (int n = 0; n < DEPTH; n++) begin
        v = sat32(v + x[n] - h[0]);
        code = v >>> SH;
        if (code > (2**(Q_BITS-1)) - 1) code = (2**(Q_BITS-1)) - 1;
        if (code < -(2**(Q_BITS-1))) code = -(2**(Q_BITS-1));
        d = code * (64'sd1 << SH);
        sum = d;
        for (int j = 0; j < TAPS - 1; j++) sum = sum + h[j];
        g[n] = sum >>> TSH;
        for (int j = TAPS - 2; j > 0; j--) h[j] = h[j-1];
        h[0] = d;
      end
      for (int n = 0; n < DEPTH; n++) begin
        r = rec[n] - g[n];
        p = r * lam;
        x[n] = sat32(x[n] + sat32((p + (64'sd1 << (LAM_FRAC - 1))) >>> LAM_FRAC));
      end
    end
    for (int n = 0; n < DEPTH; n++) expv[n] = x[n];
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_record(string tag, int npass, int lam, bit stall, bit poke);
    int k;
    int cyc;
    bit blocked;
    model(npass, lam);
    @(negedge clk);
    check(busy == 1'b0 && in_ready == 1'b1, "R1 idle before load", {busy, in_ready}, 2'b01);
    pass_count = PASS_W'(npass);
    relax = LAM_W'(lam);
    for (int i = 0; i < DEPTH; i++) begin
      in_valid = 1'b1;
      in_data = DATA_W'(rec[i]);
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    #1;
    check(busy == 1'b1 && in_ready == 1'b0, "R1 busy and closed after record", {busy, in_ready}, 2'b10);
    if (poke) begin
      // R7 and R10: settings change and stray words while the job runs.
      pass_count = PASS_W'(9);
      relax = LAM_W'(200);
      in_valid = 1'b1;
      in_data = 32'h1234_5678;
      blocked = 1'b1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        #1;
        if (in_ready) blocked = 1'b0;
      end
      in_valid = 1'b0;
      check(blocked, "R10 input refused while busy", blocked, 1);
    end
    k = 0;
    cyc = 0;
    while (k < DEPTH) begin
      @(negedge clk);
      out_ready = !stall || (cyc % 3 == 2);
      cyc++;
      #1;
      if (out_valid && out_ready) begin
        check(longint'($signed(out_data)) == expv[k], tag, longint'($signed(out_data)), expv[k]);
        k++;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    #1;
    check(busy == 1'b0 && in_ready == 1'b1, "R9 busy falls after last word", {busy, in_ready}, 2'b01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    #1;
    check(busy == 1'b0 && out_valid == 1'b0 && in_ready == 1'b1, "R1 reset state",
          {busy, out_valid, in_ready}, 3'b001);
    rst = 1'b0;

    // R2: zero passes return the record unchanged.
    for (int i = 0; i < DEPTH; i++) rec[i] = 64'sd5000 * i - 64'sd17000;
    run_record("R2 pass-through", 0, 64, 0, 0);

    // R3: one pass on a constant half-scale record.
    for (int i = 0; i < DEPTH; i++) rec[i] = 64'sd32768;
    run_record("R3 modulator single pass", 1, 64, 0, 0);

    // R4 and R6: alternating record, two passes after a previous record.
    for (int i = 0; i < DEPTH; i++) rec[i] = (i % 2 == 0) ? 64'sd20000 : -64'sd20000;
    run_record("R4 filter two passes", 2, 64, 0, 0);

    // R5 and R8: fractional relaxation with rounding, stalled output.
    for (int i = 0; i < DEPTH; i++) rec[i] = 64'sd7001 * i - 64'sd24000;
    run_record("R5/R8 relax 1.5 three passes stalled", 3, 96, 1, 0);

    // R6: maximum pass count, state restarts every pass.
    for (int i = 0; i < DEPTH; i++) rec[i] = (i < 4) ? 64'sd45000 : -64'sd12345;
    run_record("R6 fifteen passes", 15, 32, 0, 0);

    // R11: full-scale record with the largest relaxation.
    for (int i = 0; i < DEPTH; i++) rec[i] = (i % 2 == 0) ? 64'sd2147483647 : -64'sd2147483648;
    run_record("R11 saturation", 2, 255, 1, 0);

    // R7 and R10: settings changed and words offered mid-job.
    for (int i = 0; i < DEPTH; i++) rec[i] = 64'sd3000 * (i % 3) + 64'sd1000;
    run_record("R7/R10 captured settings", 2, 64, 0, 1);

    // R3: zero record stays zero.
    for (int i = 0; i < DEPTH; i++) rec[i] = 0;
    run_record("R3 zero record", 1, 64, 1, 0);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule